// File: doc/BRIEF.md
# Dual-Channel Serial Controller

This block is a two-channel asynchronous serial controller reached through a small register bus. The bus has a 4-bit address, separate read and write strobes, and an 8-bit data path. Channel A occupies the low half of the address space and channel B the upper half. A group of shared registers covers interrupt status, the interrupt mask and an interrupt vector.

Each channel has the following parts:
- two mode bytes, which sit behind a single address and are reached through a pointer that advances by itself;
- a write-only command byte;
- a status byte;
- a one-byte transmit holding register;
- a three-entry receive FIFO.

Software sets the character length, the parity and the stop length in the mode bytes. It then starts and stops each direction and clears flags through the command byte. Serial timing comes from a per-channel enable input that pulses at sixteen times the bit rate. The receiver samples each bit at its centre.

A read returns its data one clock after the read strobe. Reading the receive buffer removes the oldest character. An access to the first mode byte moves the pointer to the second one.

Top module: `dual_uart`

## Requirements
- R1: Address map. Offsets 0..3 belong to channel A and offsets 8..11 to channel B, both in this order: mode, status on read (clock select on write, ignored), command, and receive buffer on read (transmit holding on write). Offset 5 reads the interrupt status and writes the interrupt mask. Offset 12 is the vector register and can be read and written. Offset 4 and all unused offsets read 0x00. Read data appears on `rdata` one clock after `rd_en`.
- R2: Mode pointer. One address reaches both mode bytes. After reset or after the pointer-reset command, the next read or write reaches mode byte 1. Any access to mode byte 1 moves the pointer to mode byte 2, and the pointer stays there.
- R3: Mode fields. In mode byte 1, bits[1:0] give 5 + value data bits. Bit 2 set selects odd parity and clear selects even parity. Parity is generated and checked only when bits[4:3] = 00. In mode byte 2, a low nibble of 0xF gives two stop bits; any other value gives one. A frame is a low start bit, then data LSB first, then parity if enabled, then high stop bits. Received data bits above the character length read as 0.
- R4: Status bit 5 sets when a received character's parity bit does not match the selected parity. The character is still stored.
- R5: Status bit 6 sets when a character's first stop bit is sampled low but the frame is not all zeros. The character is stored. The receiver then waits for the line to go high before it looks for a new start bit.
- R6: Break. A frame whose data and parity bits and stop bit are all sampled low stores no character. It sets status bit 7 and the channel's break-change interrupt bit. Command field 6 holds the transmit line low and command field 7 releases it.
- R7: Enables. In the command byte, bit 3 disables the transmitter, bit 2 enables it, bit 1 disables the receiver and bit 0 enables it; a disable wins when both bits of a pair are set. Status bit 2 (transmitter ready) is set when the transmitter is enabled and the holding register is empty. Status bit 3 (transmitter empty) additionally requires that the shifter is idle. A write to the holding register while the transmitter is disabled is ignored. A disabled receiver ignores the line.
- R8: Receive FIFO. Status bit 0 is set while the FIFO holds a character, and bit 1 is set when it holds three. Reads return characters in arrival order. A character that arrives while the FIFO is full is dropped and sets status bit 4.
- R9: Interrupt status bits, from 7 down to 0, are: 0, B break change, B receive ready, B transmit ready, 0, A break change, A receive ready, A transmit ready. One clock later, `irq` equals the OR of status AND mask.
- R10: Reset sets both mode pointers to mode byte 1 and disables every receiver and transmitter. It clears all flags, the FIFOs and the mask, loads the vector register with 0x0F and drives both transmit lines high.
- R11: Command field bits[6:4]: 1 resets the mode pointer; 2 resets the receiver, which disables it, empties its FIFO and clears status bits 7..4; 3 resets the transmitter, which disables it and drops any pending character; 4 clears status bits 7..4; 5 clears the channel's break-change interrupt bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| tick_a | input | 1 | Channel A 16x bit-rate enable |
| tick_b | input | 1 | Channel B 16x bit-rate enable |
| rxd_a | input | 1 | Channel A serial input |
| rxd_b | input | 1 | Channel B serial input |
| txd_a | output | 1 | Channel A serial output |
| txd_b | output | 1 | Channel B serial output |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle:
- the pointer-reset command always leaves the mode pointer on mode byte 1;
- a full FIFO that receives a character always raises the overrun flag;
- the FIFO count never exceeds its depth;
- a disabled transmitter never starts a frame;
- a zero mask always forces `irq` low on the next cycle;
- the vector register leaves reset holding 0x0F.

Some behaviour only the bench scenarios can show. Correct framing for each length, parity and stop combination is checked by looping channel A's output into channel B. The bench also checks that parity and framing errors are flagged by deliberately mismatched settings, and that a held-low line is detected as a break. It checks FIFO ordering and the handling of writes that the block must ignore.

// File: rtl/du_pkg.sv
package du_pkg;
  localparam int DW = 8;

  typedef struct packed {
    logic [1:0] len;
    logic       odd;
    logic       par_en;
    logic       stop2;
  } frame_cfg_t;

  localparam logic [2:0] CMD_PTR_RST = 3'd1;
  localparam logic [2:0] CMD_RX_RST  = 3'd2;
  localparam logic [2:0] CMD_TX_RST  = 3'd3;
  localparam logic [2:0] CMD_ERR_CLR = 3'd4;
  localparam logic [2:0] CMD_BRK_CLR = 3'd5;
  localparam logic [2:0] CMD_BRK_ON  = 3'd6;
  localparam logic [2:0] CMD_BRK_OFF = 3'd7;

  function automatic frame_cfg_t decode_cfg(input logic [7:0] m1, input logic [7:0] m2);
    frame_cfg_t c;
    c.len    = m1[1:0];
    c.odd    = m1[2];
    c.par_en = (m1[4:3] == 2'b00);
    c.stop2  = (m2[3:0] == 4'hF);
    return c;
  endfunction

  function automatic logic [7:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction
endpackage

// File: rtl/du_tx.sv
module du_tx
  import du_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  frame_cfg_t    cfg,
  input  logic          load,
  input  logic [DW-1:0] ldata,
  input  logic          brk,
  input  logic          flush,
  output logic          thr_full,
  output logic          busy,
  output logic          txd
);
  localparam int FW = 1 + DW + 1 + 2;

  logic [DW-1:0] thr_q;
  logic [FW-1:0] sh_q, frame;
  logic [3:0]    left_q, tcnt_q, nd, total;
  logic          dpar, txd_q;

  always_comb begin
    nd    = 4'd5 + {2'b00, cfg.len};
    dpar  = ^(thr_q & len_mask(cfg.len));
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DW; i++)
      if (i < int'(nd)) frame[i+1] = thr_q[i];
    if (cfg.par_en) frame[4'(nd + 4'd1)] = dpar ^ cfg.odd;
    total = 4'd1 + nd + {3'b000, cfg.par_en} + (cfg.stop2 ? 4'd2 : 4'd1);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      thr_full <= 1'b0;
      busy     <= 1'b0;
      sh_q     <= '1;
      left_q   <= '0;
      tcnt_q   <= '0;
    end else begin
      if (load && en && !thr_full) begin
        thr_q    <= ldata;
        thr_full <= 1'b1;
      end
      if (!busy) begin
        if (thr_full && en) begin
          sh_q     <= frame;
          left_q   <= total;
          tcnt_q   <= '0;
          busy     <= 1'b1;
          thr_full <= 1'b0;
        end
      end else if (tick) begin
        tcnt_q <= tcnt_q + 4'd1;
        if (tcnt_q == 4'd15) begin
          sh_q   <= {1'b1, sh_q[FW-1:1]};
          left_q <= left_q - 4'd1;
          if (left_q == 4'd1) busy <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) txd_q <= 1'b1;
    else     txd_q <= brk ? 1'b0 : (busy ? sh_q[0] : 1'b1);
  end
  assign txd = txd_q;

  p_no_start_disabled_r7: assert property (@(posedge clk) disable iff (rst)
    (!en && !busy) |=> !busy);
endmodule

// File: rtl/du_rx.sv
module du_rx
  import du_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  frame_cfg_t    cfg,
  input  logic          rxd,
  output logic          push,
  output logic [DW-1:0] pdata,
  output logic          fe_evt,
  output logic          pe_evt,
  output logic          brk_evt
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_HUNT} rx_st_t;
  rx_st_t st_q;

  logic        rs1, rs2;
  logic [3:0]  tcnt_q, bidx_q, nd, last;
  logic [9:0]  bits_q, lowmask;
  logic [10:0] lm_wide;
  logic [7:0]  dval;
  logic        pbit, allzero;

  always_comb begin
    nd      = 4'd5 + {2'b00, cfg.len};
    last    = nd + {3'b000, cfg.par_en};
    lm_wide = (11'h1 << last) - 11'h1;
    lowmask = lm_wide[9:0];
    dval    = bits_q[7:0] & len_mask(cfg.len);
    pbit    = bits_q[nd];
    allzero = ((bits_q & lowmask) == 10'h0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rs1 <= 1'b1;
      rs2 <= 1'b1;
    end else begin
      rs1 <= rxd;
      rs2 <= rs1;
    end
  end

  always_ff @(posedge clk) begin
    push    <= 1'b0;
    fe_evt  <= 1'b0;
    pe_evt  <= 1'b0;
    brk_evt <= 1'b0;
    if (rst || !en) begin
      st_q   <= S_IDLE;
      tcnt_q <= '0;
      bidx_q <= '0;
      bits_q <= '0;
      pdata  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (tick && !rs2) begin
          st_q   <= S_START;
          tcnt_q <= '0;
        end
        S_START: if (tick) begin
          tcnt_q <= tcnt_q + 4'd1;
          if (tcnt_q == 4'd7) begin
            tcnt_q <= '0;
            bidx_q <= '0;
            bits_q <= '0;
            st_q   <= rs2 ? S_IDLE : S_DATA;
          end
        end
        S_DATA: if (tick) begin
          tcnt_q <= tcnt_q + 4'd1;
          if (tcnt_q == 4'd15) begin
            tcnt_q <= '0;
            if (bidx_q == last) begin
              if (!rs2 && allzero) begin
                brk_evt <= 1'b1;
                st_q    <= S_HUNT;
              end else begin
                push   <= 1'b1;
                pdata  <= dval;
                fe_evt <= !rs2;
                pe_evt <= cfg.par_en && ((^dval ^ pbit) != cfg.odd);
                st_q   <= rs2 ? S_IDLE : S_HUNT;
              end
            end else begin
              bits_q[bidx_q] <= rs2;
              bidx_q         <= bidx_q + 4'd1;
            end
          end
        end
        default: if (rs2) st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/du_fifo.sv
module du_fifo #(
  parameter int DEPTH = 3,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_pop  = pop && (count != '0);
  assign do_push = push && ((count != CW'(DEPTH)) || do_pop);
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= din;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/du_chan.sv
module du_chan
  import du_pkg::*;
#(
  parameter int FIFO_DEPTH = 3,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    a,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          tick,
  input  logic          rxd,
  output logic          txd,
  output logic          txrdy,
  output logic          rxrdy,
  output logic          brkchg
);
  logic [7:0]    mr1_q, mr2_q;
  logic          ptr_q, tx_en, rx_en, fe_q, pe_q, ovr_q, rbrk_q, brk_on;
  logic          wr_hit, rd_hit, cmd_wr, rx_flush, tx_flush, pop;
  logic          thr_full, tx_busy, rx_push, fe_evt, pe_evt, brk_evt, ovr_evt;
  logic [DW-1:0] rx_data, fifo_out;
  logic [CW-1:0] fifo_cnt;
  logic [2:0]    field;
  frame_cfg_t    cfg;

  assign cfg      = decode_cfg(mr1_q, mr2_q);
  assign wr_hit   = sel && wr;
  assign rd_hit   = sel && rd;
  assign cmd_wr   = wr_hit && (a == 2'd2);
  assign field    = wdata[6:4];
  assign rx_flush = cmd_wr && (field == CMD_RX_RST);
  assign tx_flush = cmd_wr && (field == CMD_TX_RST);
  assign pop      = rd_hit && (a == 2'd3);
  assign ovr_evt  = rx_push && (fifo_cnt == CW'(FIFO_DEPTH)) && !pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      mr1_q  <= '0;
      mr2_q  <= '0;
      ptr_q  <= 1'b0;
      tx_en  <= 1'b0;
      rx_en  <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
      ovr_q  <= 1'b0;
      rbrk_q <= 1'b0;
      brkchg <= 1'b0;
      brk_on <= 1'b0;
    end else begin
      if (wr_hit && a == 2'd0) begin
        if (ptr_q) mr2_q <= wdata;
        else begin
          mr1_q <= wdata;
          ptr_q <= 1'b1;
        end
      end
      if (rd_hit && a == 2'd0 && !ptr_q) ptr_q <= 1'b1;
      if (cmd_wr) begin
        if (wdata[3])      tx_en <= 1'b0;
        else if (wdata[2]) tx_en <= 1'b1;
        if (wdata[1])      rx_en <= 1'b0;
        else if (wdata[0]) rx_en <= 1'b1;
        case (field)
          CMD_PTR_RST: ptr_q <= 1'b0;
          CMD_RX_RST: begin
            rx_en <= 1'b0;
            {rbrk_q, fe_q, pe_q, ovr_q} <= '0;
          end
          CMD_TX_RST:  tx_en <= 1'b0;
          CMD_ERR_CLR: {rbrk_q, fe_q, pe_q, ovr_q} <= '0;
          CMD_BRK_CLR: brkchg <= 1'b0;
          CMD_BRK_ON:  brk_on <= 1'b1;
          CMD_BRK_OFF: brk_on <= 1'b0;
          default: ;
        endcase
      end
      if (fe_evt)  fe_q  <= 1'b1;
      if (pe_evt)  pe_q  <= 1'b1;
      if (ovr_evt) ovr_q <= 1'b1;
      if (brk_evt) begin
        rbrk_q <= 1'b1;
        brkchg <= 1'b1;
      end
    end
  end

  du_tx u_tx (
    .clk(clk), .rst(rst), .tick(tick), .en(tx_en), .cfg(cfg),
    .load(wr_hit && a == 2'd3), .ldata(wdata), .brk(brk_on), .flush(tx_flush),
    .thr_full(thr_full), .busy(tx_busy), .txd(txd)
  );

  du_rx u_rx (
    .clk(clk), .rst(rst), .tick(tick), .en(rx_en), .cfg(cfg), .rxd(rxd),
    .push(rx_push), .pdata(rx_data), .fe_evt(fe_evt), .pe_evt(pe_evt), .brk_evt(brk_evt)
  );

  du_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) u_fifo (
    .clk(clk), .rst(rst), .flush(rx_flush), .push(rx_push), .din(rx_data),
    .pop(pop), .dout(fifo_out), .count(fifo_cnt)
  );

  assign txrdy = tx_en && !thr_full;
  assign rxrdy = (fifo_cnt != '0);

  always_comb begin
    case (a)
      2'd0: rdata = ptr_q ? mr2_q : mr1_q;
      2'd1: rdata = {rbrk_q, fe_q, pe_q, ovr_q, txrdy && !tx_busy, txrdy,
                     fifo_cnt == CW'(FIFO_DEPTH), rxrdy};
      2'd3: rdata = fifo_out;
      default: rdata = '0;
    endcase
  end

  p_ptr_reset_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && field == CMD_PTR_RST) |=> !ptr_q);
  p_ovr_on_full_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_push && fifo_cnt == CW'(FIFO_DEPTH) && !pop) |=> ovr_q);
endmodule

// File: rtl/dual_uart.sv
module dual_uart
  import du_pkg::*;
#(
  parameter int         FIFO_DEPTH = 3,
  parameter logic [7:0] VEC_RESET  = 8'h0F
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tick_a,
  input  logic       tick_b,
  input  logic       rxd_a,
  input  logic       rxd_b,
  output logic       txd_a,
  output logic       txd_b,
  output logic       irq
);
  localparam int NCH = 2;

  logic [NCH-1:0] tick_v, rxd_v, txd_v, txrdy, rxrdy, brkchg;
  logic [7:0]     ch_rd [NCH];
  logic [7:0]     imr_q, vec_q, isr, rmux;

  assign tick_v = {tick_b, tick_a};
  assign rxd_v  = {rxd_b, rxd_a};
  assign txd_a  = txd_v[0];
  assign txd_b  = txd_v[1];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    du_chan #(.FIFO_DEPTH(FIFO_DEPTH)) u_ch (
      .clk(clk), .rst(rst),
      .sel(addr[3] == g[0] && !addr[2]),
      .wr(wr_en), .rd(rd_en), .a(addr[1:0]), .wdata(wdata), .rdata(ch_rd[g]),
      .tick(tick_v[g]), .rxd(rxd_v[g]), .txd(txd_v[g]),
      .txrdy(txrdy[g]), .rxrdy(rxrdy[g]), .brkchg(brkchg[g])
    );
  end

  assign isr = {1'b0, brkchg[1], rxrdy[1], txrdy[1], 1'b0, brkchg[0], rxrdy[0], txrdy[0]};

  always_comb begin
    if (!addr[2])          rmux = ch_rd[addr[3]];
    else if (addr == 4'h5) rmux = isr;
    else if (addr == 4'hC) rmux = vec_q;
    else                   rmux = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      imr_q <= '0;
      vec_q <= VEC_RESET;
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (wr_en && addr == 4'h5) imr_q <= wdata;
      if (wr_en && addr == 4'hC) vec_q <= wdata;
      if (rd_en) rdata <= rmux;
      irq <= |(isr & imr_q);
    end
  end

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (imr_q == 8'h00) |=> !irq);
  p_vec_reset_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (vec_q == VEC_RESET));
endmodule

// File: tb/dual_uart_tb.sv
module dual_uart_tb;
  logic       clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       txd_a, txd_b, irq;
  int         total = 0, bad = 0;
  logic       done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  dual_uart u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .tick_a(tick), .tick_b(tick),
    .rxd_a(txd_b), .rxd_b(txd_a), .txd_a(txd_a), .txd_b(txd_b), .irq(irq)
  );

  // {mode1, mode2, sent char, expected received char}
  localparam logic [31:0] VT [0:5] = '{
    32'h13_07_A5_A5, 32'h02_07_D3_53, 32'h04_0F_3F_1F,
    32'h11_0F_2A_2A, 32'h07_07_00_00, 32'h03_0F_FF_FF
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rchk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic cfg(input logic [3:0] base, input logic [7:0] m1, input logic [7:0] m2);
    wr(base + 4'd2, 8'h15);
    wr(base, m1);
    wr(base, m2);
  endtask

  task automatic waitc();
    repeat (450) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 1'b0, 1'b1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 txd_a idle", {7'd0, txd_a}, 8'h01);
    chk("R10 irq low", {7'd0, irq}, 8'h00);
    rchk(4'h1, 8'h00, "R10 status A");
    rchk(4'h9, 8'h00, "R10 status B");
    rchk(4'h5, 8'h00, "R10 isr");
    rchk(4'hC, 8'h0F, "R10 vector");
    // R1 decode
    wr(4'hC, 8'hA7);
    rchk(4'hC, 8'hA7, "R1 vector rw");
    rchk(4'h4, 8'h00, "R1 offset4");
    rchk(4'hD, 8'h00, "R1 unused");
    // R2 mode pointer
    wr(4'h2, 8'h10); wr(4'h0, 8'h13); wr(4'h0, 8'h07);
    wr(4'h2, 8'h10);
    rchk(4'h0, 8'h13, "R2 mr1");
    rchk(4'h0, 8'h07, "R2 mr2");
    rchk(4'h0, 8'h07, "R2 stays mr2");
    // R3 frame formats via loopback A->B
    for (int k = 0; k < 6; k++) begin
      cfg(4'h0, VT[k][31:24], VT[k][23:16]);
      cfg(4'h8, VT[k][31:24], VT[k][23:16]);
      wr(4'h3, VT[k][15:8]);
      waitc();
      rchk(4'h9, 8'h0D, "R3 status");
      rchk(4'hB, VT[k][7:0], "R3 data");
    end
    // R4 parity mismatch
    cfg(4'h0, 8'h03, 8'h07); cfg(4'h8, 8'h07, 8'h07);
    wr(4'h3, 8'h11); waitc();
    rchk(4'h9, 8'h2D, "R4 parity flag");
    rchk(4'hB, 8'h11, "R4 data kept");
    wr(4'hA, 8'h40);
    rchk(4'h9, 8'h0C, "R11 err clear");
    // R5 framing error
    cfg(4'h0, 8'h13, 8'h07); cfg(4'h8, 8'h10, 8'h07);
    wr(4'h3, 8'h01); waitc();
    rchk(4'h9, 8'h4D, "R5 framing flag");
    rchk(4'hB, 8'h01, "R5 data");
    wr(4'hA, 8'h40);
    // R6 break
    cfg(4'h8, 8'h13, 8'h07);
    wr(4'h5, 8'h40);
    wr(4'h2, 8'h60);
    repeat (5) @(negedge clk);
    chk("R6 line low", {7'd0, txd_a}, 8'h00);
    waitc(); waitc();
    rchk(4'h9, 8'h8C, "R6 break status");
    rchk(4'h5, 8'h51, "R9 isr break");
    chk("R9 irq on break", {7'd0, irq}, 8'h01);
    wr(4'h2, 8'h70); waitc();
    wr(4'hA, 8'h50);
    rchk(4'h5, 8'h11, "R11 brkchg clear");
    repeat (3) @(negedge clk);
    chk("R9 irq cleared", {7'd0, irq}, 8'h00);
    wr(4'hA, 8'h40);
    wr(4'h5, 8'h00);
    // R8 FIFO and overrun
    for (int k = 0; k < 4; k++) begin
      wr(4'h3, 8'h31 + 8'(k)); waitc();
    end
    rchk(4'h9, 8'h1F, "R8 full+overrun");
    rchk(4'hB, 8'h31, "R8 order0");
    rchk(4'hB, 8'h32, "R8 order1");
    rchk(4'hB, 8'h33, "R8 order2");
    rchk(4'h9, 8'h1C, "R8 empty, overrun sticky");
    wr(4'hA, 8'h40);
    // R9 interrupt mask
    wr(4'h5, 8'h02);
    wr(4'hB, 8'h5A); waitc();
    chk("R9 irq rxrdy A", {7'd0, irq}, 8'h01);
    rchk(4'h5, 8'h13, "R9 isr bits");
    wr(4'h5, 8'h00);
    repeat (3) @(negedge clk);
    chk("R9 irq masked", {7'd0, irq}, 8'h00);
    rchk(4'h3, 8'h5A, "R9 data A");
    // R7 enables
    wr(4'hA, 8'h02);
    wr(4'h3, 8'h77); waitc();
    rchk(4'h9, 8'h0C, "R7 rx disabled ignores line");
    wr(4'h2, 8'h08);
    rchk(4'h1, 8'h00, "R7 tx disabled status");
    wr(4'h3, 8'h66);
    wr(4'hA, 8'h01);
    wr(4'h2, 8'h04); waitc();
    rchk(4'h9, 8'h0C, "R7 write while disabled ignored");
    // R11 receiver and transmitter reset
    wr(4'h3, 8'h44); waitc();
    rchk(4'h9, 8'h0D, "R11 pre-reset");
    wr(4'hA, 8'h20);
    wr(4'hA, 8'h01);
    rchk(4'h9, 8'h0C, "R11 rx reset flushes");
    wr(4'h2, 8'h30);
    rchk(4'h1, 8'h00, "R11 tx reset disables");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule